// File: doc/BRIEF.md
# Power domain keep-awake sensitivity matrix

This block decides, for each power domain in a small system, whether that domain has to stay powered. There are six domains: one system domain, four SRAM domains and one crypto domain. Each domain owns a 32-bit sensitivity register. A set bit makes the domain sensitive to one source: a domain's ON status or an external expansion request. A domain's keep-awake output is high while any source it is sensitive to is active.

Software programs the registers over a simple 32-bit register bus. Some bits in each register are fixed by the hardware. In the system register they read 1, so the system domain always follows the CPU and SRAM domains. In the SRAM registers, the SRAM bits that belong to the other SRAMs and the crypto bit read 0. The crypto register is fixed entirely at zero. Fixed bits ignore writes.

The keep-awake outputs are purely combinational from the registers and the status inputs. They feed the power policy logic, which is outside this block. The registers are reset by the always-on warm reset.

Top module: `pdsm_matrix`

## Requirements
- R1: After reset, the system register (offset 0x200) reads 0x0000_107F. The SRAM registers at offsets 0x20C, 0x210, 0x214 and 0x218 (SRAM0 to SRAM3) read 0. The crypto register at offset 0x21C reads 0.
- R2: The source bit positions are the same in every register. Bit 0 is system ON, bits 1 and 2 are CPU0 and CPU1 core ON, bits 3 to 6 are SRAM0 to SRAM3 ON, bit 12 is crypto ON, and bits 16 to 19 are expansion requests 0 to 3.
- R3: In the system register, only bit 0 and bits 16 to 19 are writable. Bits 1 to 6 and bit 12 always read 1. Every other bit reads 0.
- R4: In SRAM register n, bits 0 to 2, bit 3+n and bits 16 to 19 are writable. Every other bit, including the crypto bit 12, always reads 0.
- R5: The crypto register always reads 0 and ignores writes. The crypto keep-awake output is always 0, whatever the inputs are.
- R6: Each domain's keep-awake output is the OR, over all bit positions, of (sensitivity bit AND the source at that position).
- R7: A write changes a register only when the size code is 2'b10 (full word). Size codes 2'b00 (byte) and 2'b01 (halfword) leave every register unchanged.
- R8: Offsets 0x204, 0x208 and every unmapped offset read 0. Writes to those offsets change no register.
- R9: A full-word write updates the register at the clock edge where bus_sel and bus_write are both high. The keep-awake outputs reflect the new value from that edge on. Read data equals the addressed register combinationally while bus_sel is high and bus_write is low; otherwise read data is 0.
- R10: An active-low rst_n, applied at any time, returns every register to its R1 value at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Always-on warm reset, asynchronous, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| sys_on | input | 1 | System domain is ON |
| cpu_on | input | 2 | CPU core domains ON, bit k = CPUk |
| sram_on | input | NUM_SRAM | SRAM domains ON, bit n = SRAMn |
| crypto_on | input | 1 | Crypto domain is ON |
| exp_in | input | 4 | External expansion keep-awake requests |
| keep_sys | output | 1 | System domain must stay awake |
| keep_sram | output | NUM_SRAM | SRAM domain n must stay awake |
| keep_crypto | output | 1 | Crypto domain must stay awake (always 0) |

## Verification
A corrupted sensitivity bit does not stay hidden. It shows on the read data the next time that offset is read. It also shows on the keep-awake outputs in the same cycle its source changes, because there is no register between the inputs and those outputs. A fixed bit that becomes writable shows as a changed read value one clock after the write. A size or address decode fault shows as a register that changes after a byte write, a halfword write or a reserved-offset write. The bench reads every register back after each such write.

// File: rtl/pdsm_pkg.sv
package pdsm_pkg;

  localparam int REG_W      = 32;
  localparam int SRC_SYS    = 0;
  localparam int SRC_CPU0   = 1;
  localparam int NUM_CPU    = 2;
  localparam int SRC_SRAM0  = 3;
  localparam int SRC_CRYPTO = 12;
  localparam int SRC_EXP0   = 16;
  localparam int NUM_EXP    = 4;

  // Domain index: 0 = system, 1..nsram = SRAM0.., nsram+1 = crypto.

  // Mask of the bits software may write in a domain's register.
  function automatic logic [REG_W-1:0] dom_wmask(int dom, int nsram);
    logic [REG_W-1:0] m;
    m = '0;
    if (dom == 0) begin
      m[SRC_SYS] = 1'b1;
      for (int k = 0; k < NUM_EXP; k++) m[SRC_EXP0 + k] = 1'b1;
    end else if (dom <= nsram) begin
      m[SRC_SYS] = 1'b1;
      for (int k = 0; k < NUM_CPU; k++) m[SRC_CPU0 + k] = 1'b1;
      m[SRC_SRAM0 + dom - 1] = 1'b1;
      for (int k = 0; k < NUM_EXP; k++) m[SRC_EXP0 + k] = 1'b1;
    end
    return m;
  endfunction

  // Bits fixed at 1: only the system domain has any.
  function automatic logic [REG_W-1:0] dom_tied1(int dom, int nsram);
    logic [REG_W-1:0] m;
    m = '0;
    if (dom == 0) begin
      for (int k = 0; k < NUM_CPU; k++) m[SRC_CPU0 + k] = 1'b1;
      for (int k = 0; k < nsram; k++) m[SRC_SRAM0 + k] = 1'b1;
      m[SRC_CRYPTO] = 1'b1;
    end
    return m;
  endfunction

  // Reset value of the writable bits.
  function automatic logic [REG_W-1:0] dom_rstval(int dom);
    logic [REG_W-1:0] m;
    m = '0;
    if (dom == 0) m[SRC_SYS] = 1'b1;
    return m;
  endfunction

  // Byte offset of a domain's register.
  function automatic logic [REG_W-1:0] dom_offset(int dom, int nsram);
    logic [REG_W-1:0] off;
    if (dom == 0)          off = 32'h200;
    else if (dom <= nsram) off = 32'h20C + 32'(4 * (dom - 1));
    else                   off = 32'h21C;
    return off;
  endfunction

  // Keep-awake decision for one domain.
  function automatic logic any_awake(logic [REG_W-1:0] sense, logic [REG_W-1:0] src);
    return |(sense & src);
  endfunction

endpackage

// File: rtl/pdsm_sense_reg.sv
module pdsm_sense_reg
  import pdsm_pkg::*;
#(
  parameter int DOM      = 0,
  parameter int NUM_SRAM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] sense
);

  localparam logic [REG_W-1:0] WMASK = dom_wmask(DOM, NUM_SRAM);
  localparam logic [REG_W-1:0] TIED1 = dom_tied1(DOM, NUM_SRAM);
  localparam logic [REG_W-1:0] RSTV  = dom_rstval(DOM) & WMASK;

  logic [REG_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RSTV;
    else if (wr_en) q <= (wdata & WMASK) | (q & ~WMASK);
  end

  // Writable bits come from storage, fixed bits from the constants.
  assign sense = (q & WMASK) | TIED1;

endmodule

// File: rtl/pdsm_bus_dec.sv
module pdsm_bus_dec
  import pdsm_pkg::*;
#(
  parameter int NUM_SRAM = 4,
  parameter int NUM_DOM  = NUM_SRAM + 2,
  parameter int ADDR_W   = 12
) (
  input  logic                     bus_sel,
  input  logic                     bus_write,
  input  logic [1:0]               bus_size,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [NUM_DOM*REG_W-1:0] sense_flat,
  output logic                     wr_fire,
  output logic [NUM_DOM-1:0]       wr_hit,
  output logic [REG_W-1:0]         bus_rdata
);

  localparam logic [1:0] SIZE_WORD = 2'b10;

  logic [NUM_DOM-1:0] addr_hit;
  logic               rd_fire;

  assign wr_fire = bus_sel & bus_write & (bus_size == SIZE_WORD);
  assign rd_fire = bus_sel & ~bus_write;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dec
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(dom_offset(d, NUM_SRAM));
    assign addr_hit[d] = (bus_addr == OFF);
    assign wr_hit[d]   = wr_fire & addr_hit[d];
  end

  always_comb begin
    bus_rdata = '0;
    for (int d = 0; d < NUM_DOM; d++)
      if (rd_fire && addr_hit[d]) bus_rdata = sense_flat[d*REG_W +: REG_W];
  end

endmodule

// File: rtl/pdsm_keep_eval.sv
module pdsm_keep_eval
  import pdsm_pkg::*;
#(
  parameter int NUM_SRAM = 4,
  parameter int NUM_DOM  = NUM_SRAM + 2
) (
  input  logic [NUM_DOM*REG_W-1:0] sense_flat,
  input  logic                     sys_on,
  input  logic [NUM_CPU-1:0]       cpu_on,
  input  logic [NUM_SRAM-1:0]      sram_on,
  input  logic                     crypto_on,
  input  logic [NUM_EXP-1:0]       exp_in,
  output logic [REG_W-1:0]         src_vec,
  output logic [NUM_DOM-1:0]       keep
);

  always_comb begin
    src_vec                          = '0;
    src_vec[SRC_SYS]                 = sys_on;
    src_vec[SRC_CPU0 +: NUM_CPU]     = cpu_on;
    src_vec[SRC_SRAM0 +: NUM_SRAM]   = sram_on;
    src_vec[SRC_CRYPTO]              = crypto_on;
    src_vec[SRC_EXP0 +: NUM_EXP]     = exp_in;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_keep
    assign keep[d] = any_awake(sense_flat[d*REG_W +: REG_W], src_vec);
  end

endmodule

// File: rtl/pdsm_matrix.sv
// NUM_SRAM must lie in 1..4: the SRAM bits occupy positions 3..6.
module pdsm_matrix
  import pdsm_pkg::*;
#(
  parameter int NUM_SRAM = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_write,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                sys_on,
  input  logic [1:0]          cpu_on,
  input  logic [NUM_SRAM-1:0] sram_on,
  input  logic                crypto_on,
  input  logic [3:0]          exp_in,
  output logic                keep_sys,
  output logic [NUM_SRAM-1:0] keep_sram,
  output logic                keep_crypto
);

  localparam int NUM_DOM = NUM_SRAM + 2;

  logic                     wr_fire;
  logic [NUM_DOM-1:0]       wr_hit;
  logic [NUM_DOM*REG_W-1:0] sense_flat;
  logic [REG_W-1:0]         src_vec;
  logic [NUM_DOM-1:0]       keep;

  pdsm_bus_dec #(.NUM_SRAM(NUM_SRAM), .NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W)) u_dec (
    .bus_sel    (bus_sel),
    .bus_write  (bus_write),
    .bus_size   (bus_size),
    .bus_addr   (bus_addr),
    .sense_flat (sense_flat),
    .wr_fire    (wr_fire),
    .wr_hit     (wr_hit),
    .bus_rdata  (bus_rdata)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_reg
    pdsm_sense_reg #(.DOM(d), .NUM_SRAM(NUM_SRAM)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_hit[d]),
      .wdata (bus_wdata),
      .sense (sense_flat[d*REG_W +: REG_W])
    );
  end

  pdsm_keep_eval #(.NUM_SRAM(NUM_SRAM), .NUM_DOM(NUM_DOM)) u_eval (
    .sense_flat (sense_flat),
    .sys_on     (sys_on),
    .cpu_on     (cpu_on),
    .sram_on    (sram_on),
    .crypto_on  (crypto_on),
    .exp_in     (exp_in),
    .src_vec    (src_vec),
    .keep       (keep)
  );

  assign keep_sys    = keep[0];
  assign keep_sram   = keep[NUM_SRAM:1];
  assign keep_crypto = keep[NUM_DOM-1];

endmodule

// File: rtl/pdsm_matrix_chk.sv
module pdsm_matrix_chk
  import pdsm_pkg::*;
#(
  parameter int NUM_SRAM = 4,
  parameter int NUM_DOM  = NUM_SRAM + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic                     bus_write,
  input logic [1:0]               bus_size,
  input logic [NUM_DOM-1:0]       wr_hit,
  input logic [NUM_DOM*REG_W-1:0] sense_flat,
  input logic [REG_W-1:0]         src_vec,
  input logic                     keep_sys,
  input logic                     keep_crypto
);

  localparam logic [REG_W-1:0] SYS_T1 = dom_tied1(0, NUM_SRAM);

  // R7
  size_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_write && bus_size != 2'b10) |-> (wr_hit == '0));

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit == '0) |=> $stable(sense_flat));

  // R3
  sys_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sense_flat[REG_W-1:0] & SYS_T1) == SYS_T1));

  // R6
  sys_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_flat[SRC_SYS] && src_vec[SRC_SYS]) |-> keep_sys);

  // R5
  crypto_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_crypto);

  for (genvar d = 1; d <= NUM_SRAM; d++) begin : g_sram_chk
    // R4
    sram_crypto_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_flat[d*REG_W + SRC_CRYPTO]);
  end

endmodule

bind pdsm_matrix pdsm_matrix_chk #(.NUM_SRAM(NUM_SRAM), .NUM_DOM(NUM_SRAM + 2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_write   (bus_write),
  .bus_size    (bus_size),
  .wr_hit      (wr_hit),
  .sense_flat  (sense_flat),
  .src_vec     (src_vec),
  .keep_sys    (keep_sys),
  .keep_crypto (keep_crypto)
);

// File: tb/pdsm_matrix_test.sv
`timescale 1ns/1ps
module pdsm_matrix_test;

  localparam int NS = 4;
  localparam int ND = NS + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'b10;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_on = 1'b0, crypto_on = 1'b0;
  logic [1:0]  cpu_on = '0;
  logic [NS-1:0] sram_on = '0;
  logic [3:0]  exp_in = '0;
  logic        keep_sys, keep_crypto;
  logic [NS-1:0] keep_sram;

  int checks = 0;
  int errors = 0;

  logic [31:0] wm [ND];
  logic [31:0] t1 [ND];
  logic [31:0] mdl [ND];
  logic [11:0] offs [ND];

  always #4 clk = ~clk;

  pdsm_matrix #(.NUM_SRAM(NS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_on(sys_on), .cpu_on(cpu_on), .sram_on(sram_on),
    .crypto_on(crypto_on), .exp_in(exp_in), .keep_sys(keep_sys),
    .keep_sram(keep_sram), .keep_crypto(keep_crypto)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Bench model of the register contents, written from R1, R3, R4 and R5.
  task automatic model_reset();
    offs[0] = 12'h200; wm[0] = 32'h000F_0001; t1[0] = 32'h0000_107E; mdl[0] = 32'h0000_107F;
    for (int n = 0; n < NS; n++) begin
      offs[n+1] = 12'h20C + 12'(4*n);
      wm[n+1]   = 32'h000F_0007 | (32'h1 << (3 + n));
      t1[n+1]   = '0;
      mdl[n+1]  = '0;
    end
    offs[ND-1] = 12'h21C; wm[ND-1] = '0; t1[ND-1] = '0; mdl[ND-1] = '0;
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0; bus_size = 2'b10;
    if (sz == 2'b10)
      for (int k = 0; k < ND; k++)
        if (offs[k] == a) mdl[k] = (d & wm[k]) | t1[k];
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic all_regs_chk(string tag);
    for (int k = 0; k < ND; k++) rd_chk(tag, offs[k], mdl[k]);
  endtask

  // Keep-awake model from R2 and R6.
  task automatic keep_chk(string tag);
    logic [31:0] s;
    logic [ND-1:0] e;
    s = '0;
    s[0] = sys_on; s[1] = cpu_on[0]; s[2] = cpu_on[1];
    for (int n = 0; n < NS; n++) s[3+n] = sram_on[n];
    s[12] = crypto_on;
    for (int k = 0; k < 4; k++) s[16+k] = exp_in[k];
    for (int k = 0; k < ND; k++) e[k] = |(mdl[k] & s);
    #1;
    chk({tag, " keep_sys"}, 32'(keep_sys), 32'(e[0]));
    chk({tag, " keep_sram"}, 32'(keep_sram), 32'(e[NS:1]));
    chk({tag, " keep_crypto"}, 32'(keep_crypto), 32'(e[ND-1]));
  endtask

  task automatic set_src(logic s, logic [1:0] c, logic [NS-1:0] m, logic cr, logic [3:0] x);
    @(negedge clk);
    sys_on = s; cpu_on = c; sram_on = m; crypto_on = cr; exp_in = x;
  endtask

  task automatic t_reset();
    all_regs_chk("R1 reset value");
    set_src(1'b0, 2'b00, '0, 1'b0, 4'h0);
    keep_chk("R1 idle");
  endtask

  task automatic t_system();
    set_src(1'b1, 2'b00, '0, 1'b0, 4'h0);
    keep_chk("R6 sys own bit");
    bus_wr(12'h200, 32'h0000_0000, 2'b10);
    rd_chk("R3 tied ones stay", 12'h200, 32'h0000_107E);
    keep_chk("R6 sys own bit cleared");
    set_src(1'b0, 2'b10, '0, 1'b0, 4'h0);
    keep_chk("R2 cpu1 position");
    set_src(1'b0, 2'b00, '0, 1'b0, 4'h4);
    keep_chk("R6 exp2 not sensed");
    bus_wr(12'h200, 32'hFFFF_FFFF, 2'b10);
    rd_chk("R3 all-ones write", 12'h200, 32'h000F_107F);
    keep_chk("R6 exp2 sensed");
    set_src(1'b0, 2'b00, '0, 1'b1, 4'h0);
    keep_chk("R3 crypto bit tied one");
  endtask

  task automatic t_sram();
    for (int n = 0; n < NS; n++) begin
      bus_wr(offs[n+1], 32'hFFFF_FFFF, 2'b10);
      rd_chk("R4 sram writable mask", offs[n+1], 32'h000F_0007 | (32'h1 << (3+n)));
      bus_wr(offs[n+1], 32'h0000_0000, 2'b10);
    end
    bus_wr(12'h210, 32'h0000_0010, 2'b10);
    set_src(1'b0, 2'b00, 4'b0010, 1'b0, 4'h0);
    keep_chk("R4 sram1 own bit");
    set_src(1'b0, 2'b00, 4'b0100, 1'b0, 4'h0);
    keep_chk("R4 sram1 ignores sram2");
    bus_wr(12'h214, 32'h0008_0002, 2'b10);
    set_src(1'b0, 2'b01, '0, 1'b0, 4'h8);
    keep_chk("R6 sram2 cpu0 and exp3");
  endtask

  task automatic t_size();
    bus_wr(12'h200, 32'h0000_0000, 2'b01);
    bus_wr(12'h210, 32'hFFFF_FFFF, 2'b00);
    all_regs_chk("R7 narrow write ignored");
  endtask

  task automatic t_reserved();
    bus_wr(12'h204, 32'hFFFF_FFFF, 2'b10);
    bus_wr(12'h208, 32'hFFFF_FFFF, 2'b10);
    bus_wr(12'h300, 32'hFFFF_FFFF, 2'b10);
    rd_chk("R8 reserved 0x204", 12'h204, 32'h0);
    rd_chk("R8 reserved 0x208", 12'h208, 32'h0);
    rd_chk("R8 unmapped", 12'h300, 32'h0);
    all_regs_chk("R8 no side effect");
  endtask

  task automatic t_crypto();
    bus_wr(12'h21C, 32'hFFFF_FFFF, 2'b10);
    rd_chk("R5 crypto reads zero", 12'h21C, 32'h0);
    set_src(1'b1, 2'b11, 4'hF, 1'b1, 4'hF);
    keep_chk("R5 all sources on");
  endtask

  task automatic t_timing();
    bus_wr(12'h20C, 32'h0000_0000, 2'b10);
    set_src(1'b0, 2'b00, 4'b0001, 1'b0, 4'h0);
    #1 chk("R9 before write", 32'(keep_sram[0]), 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 12'h20C; bus_wdata = 32'h8; bus_size = 2'b10;
    #1 chk("R9 no change before edge", 32'(keep_sram[0]), 32'h0);
    chk("R9 rdata zero on write", bus_rdata, 32'h0);
    @(posedge clk); #1;
    chk("R9 change after edge", 32'(keep_sram[0]), 32'h1);
    bus_sel = 1'b0; bus_write = 1'b0;
    mdl[1] = 32'h8;
  endtask

  task automatic t_midreset();
    bus_wr(12'h200, 32'h000A_0000, 2'b10);
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 12'h200;
    #1 chk("R10 async reset", bus_rdata, 32'h0000_107F);
    bus_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    all_regs_chk("R10 after reset");
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_system();
    t_sram();
    t_size();
    t_reserved();
    t_crypto();
    t_timing();
    t_midreset();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule